// File: doc/BRIEF.md
# Masked calendar alarm comparator

This block watches the calendar fields kept by a separate time counter and raises an alarm event when they agree with a programmed set of alarm values. There are eight fields: second, minute, hour, day of month, day of week, day of year, month and year. Each field has its own alarm register, and a per-field mask bit can take it out of the comparison. This allows alarms such as "every day at 07:30:00" or "every minute at second 15".

The counter pulses `tick` once per update, in the cycle where the new field values sit on the inputs. The block captures the fields on that pulse and compares them in the following cycle. Each tick produces at most one alarm event, so a match that persists for a whole second does not raise a level. Every tick also records an increment event. Both events are held in a two-bit location register. Software clears each bit by writing 1 to it, and the interrupt line is high while either bit is set. A 32-bit register port gives access to the alarm values, the mask and the location register. Writing all ones to the mask switches the alarm off.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, the location register is 0, `irq` is low, every alarm register reads 0, and the mask register reads 0xFF, so the alarm is off.
- R2: Byte offsets: location register 0x00, mask 0x10, alarm registers at 0x60 + 4*i. The field order is i=0 second, 1 minute, 2 hour, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. Alarm writes keep only the field width (6, 6, 5, 5, 3, 9, 4, 12 bits) and read back zero-extended. The mask keeps bits 7:0. Any other address, including a misaligned one, reads 0.
- R3: Each `tick` sets location bit 0 (increment event) at the second rising edge after the tick cycle.
- R4: At that same edge, location bit 1 (alarm event) is set when every field whose mask bit is 0 equals its alarm register. Mask bit i (same order as R2) set to 1 excludes field i.
- R5: While the mask is 0xFF, location bit 1 is never set, even if every field matches.
- R6: The comparison uses the field values present in the tick cycle. Later changes on the field inputs do not alter that result, and field changes without a tick raise no event.
- R7: A write to an alarm or mask register accepted in the cycle after a tick cancels that tick's alarm event. The new value takes effect from the next tick.
- R8: Writing the location register clears each bit written as 1 and keeps each bit written as 0. If a clear and a set of the same bit fall on the same edge, the bit ends up set.
- R9: `irq` is high exactly when at least one location bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking freshly updated field values |
| sec_i | input | 6 | Current second |
| min_i | input | 6 | Current minute |
| hour_i | input | 5 | Current hour |
| mday_i | input | 5 | Current day of month |
| wday_i | input | 3 | Current day of week |
| yday_i | input | 9 | Current day of year |
| month_i | input | 4 | Current month |
| year_i | input | 12 | Current year |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational, no side effects) |
| irq | output | 1 | Interrupt, high while any location bit is set |
| loc_status | output | 2 | Location register: bit 1 alarm, bit 0 increment |

## Verification
The assertions assume that `tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that the field inputs are stable during the tick cycle. The bench drives every tick as one-cycle pulses separated by several cycles, and changes field values only on the falling clock edge. The random phase draws masks, alarm values (full 32-bit words, so truncation is exercised) and field values that mostly match with a few fields perturbed. Directed cases place register writes in the evaluation cycle and move the field inputs after the tick.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    parameter int NUM_FIELDS = 8;
    parameter int FIELD_W    = 12;
    parameter int FLAG_W     = 2;
    parameter int FLAG_INC   = 0;
    parameter int FLAG_ALM   = 1;

    parameter int SEC_W  = 6;
    parameter int MIN_W  = 6;
    parameter int HOUR_W = 5;
    parameter int MDAY_W = 5;
    parameter int WDAY_W = 3;
    parameter int YDAY_W = 9;
    parameter int MON_W  = 4;
    parameter int YEAR_W = 12;

    parameter int LOC_OFS      = 'h00;
    parameter int MASK_OFS     = 'h10;
    parameter int ALARM_BASE   = 'h60;
    parameter int ALARM_STRIDE = 4;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    function automatic int field_width(input int idx);
        case (idx)
            0:       return SEC_W;
            1:       return MIN_W;
            2:       return HOUR_W;
            3:       return MDAY_W;
            4:       return WDAY_W;
            5:       return YDAY_W;
            6:       return MON_W;
            default: return YEAR_W;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] field_keep(input int idx);
        return FIELD_W'((64'd1 << field_width(idx)) - 64'd1);
    endfunction
endpackage

// File: rtl/cal_alarm_field_cmp.sv
module cal_alarm_field_cmp #(
    parameter int FW = 12,
    parameter int W  = 6
) (
    input  logic [FW-1:0] snap_val,
    input  logic [FW-1:0] alarm_val,
    input  logic          skip,
    output logic          hit
);
    localparam logic [FW-1:0] KEEP = FW'((64'd1 << W) - 64'd1);

    always_comb begin
        hit = skip | (((snap_val ^ alarm_val) & KEEP) == '0);
    end
endmodule

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [FLAG_W-1:0]     flags_i,
    output logic [DATA_W-1:0]     bus_rdata,
    output field_vec_t            alarm_o,
    output logic [NUM_FIELDS-1:0] mask_o,
    output logic                  cfg_wr_o,
    output logic [FLAG_W-1:0]     clr_o
);
    localparam logic [ADDR_W-1:0] LOC_ADDR  = ADDR_W'(LOC_OFS);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);

    typedef struct packed {
        field_vec_t            alarm;
        logic [NUM_FIELDS-1:0] mask;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic unused_wdata_hi;

    function automatic logic [ADDR_W-1:0] alarm_addr(input int idx);
        return ADDR_W'(ALARM_BASE + ALARM_STRIDE * idx);
    endfunction

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:FIELD_W];

    // next-state and write decode
    always_comb begin
        cfg_d    = cfg_q;
        cfg_wr_o = 1'b0;
        clr_o    = '0;
        if (bus_wr) begin
            if (bus_addr == LOC_ADDR) begin
                clr_o = bus_wdata[FLAG_W-1:0];
            end
            if (bus_addr == MASK_ADDR) begin
                cfg_d.mask = bus_wdata[NUM_FIELDS-1:0];
                cfg_wr_o   = 1'b1;
            end
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (bus_addr == alarm_addr(i)) begin
                    cfg_d.alarm[i] = bus_wdata[FIELD_W-1:0] & field_keep(i);
                    cfg_wr_o       = 1'b1;
                end
            end
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == LOC_ADDR) begin
            bus_rdata[FLAG_W-1:0] = flags_i;
        end
        if (bus_addr == MASK_ADDR) begin
            bus_rdata[NUM_FIELDS-1:0] = cfg_q.mask;
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (bus_addr == alarm_addr(i)) begin
                bus_rdata[FIELD_W-1:0] = cfg_q.alarm[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.alarm <= '0;
            cfg_q.mask  <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign alarm_o = cfg_q.alarm;
    assign mask_o  = cfg_q.mask;
endmodule

// File: rtl/cal_alarm_event.sv
module cal_alarm_event
    import cal_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  field_vec_t            live_vec,
    input  logic [NUM_FIELDS-1:0] hits,
    input  logic [NUM_FIELDS-1:0] mask,
    input  logic                  cfg_wr,
    input  logic [FLAG_W-1:0]     clr,
    output field_vec_t            snap_o,
    output logic [FLAG_W-1:0]     flags_o
);
    typedef struct packed {
        field_vec_t        snap;
        logic              eval;
        logic [FLAG_W-1:0] flags;
    } ev_t;

    ev_t               st_q, st_d;
    logic [FLAG_W-1:0] set_v;
    logic              alarm_on;

    always_comb begin
        st_d      = st_q;
        st_d.snap = tick ? live_vec : st_q.snap;
        st_d.eval = tick;

        alarm_on        = ~(&mask);
        set_v           = '0;
        set_v[FLAG_INC] = st_q.eval;
        set_v[FLAG_ALM] = st_q.eval & (&hits) & alarm_on & ~cfg_wr;

        st_d.flags = (st_q.flags & ~clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o  = st_q.snap;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [MIN_W-1:0]  min_i,
    input  logic [HOUR_W-1:0] hour_i,
    input  logic [MDAY_W-1:0] mday_i,
    input  logic [WDAY_W-1:0] wday_i,
    input  logic [YDAY_W-1:0] yday_i,
    input  logic [MON_W-1:0]  month_i,
    input  logic [YEAR_W-1:0] year_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [FLAG_W-1:0] loc_status
);
    field_vec_t            live_vec;
    field_vec_t            snap;
    field_vec_t            alarm_q;
    logic [NUM_FIELDS-1:0] mask_q;
    logic [NUM_FIELDS-1:0] hits;
    logic                  cfg_wr;
    logic [FLAG_W-1:0]     clr;
    logic [FLAG_W-1:0]     flags;

    always_comb begin
        live_vec               = '0;
        live_vec[0][SEC_W-1:0]  = sec_i;
        live_vec[1][MIN_W-1:0]  = min_i;
        live_vec[2][HOUR_W-1:0] = hour_i;
        live_vec[3][MDAY_W-1:0] = mday_i;
        live_vec[4][WDAY_W-1:0] = wday_i;
        live_vec[5][YDAY_W-1:0] = yday_i;
        live_vec[6][MON_W-1:0]  = month_i;
        live_vec[7][YEAR_W-1:0] = year_i;
    end

    cal_alarm_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .flags_i  (flags),
        .bus_rdata(bus_rdata),
        .alarm_o  (alarm_q),
        .mask_o   (mask_q),
        .cfg_wr_o (cfg_wr),
        .clr_o    (clr)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        cal_alarm_field_cmp #(
            .FW(FIELD_W),
            .W (field_width(g))
        ) u_cmp (
            .snap_val (snap[g]),
            .alarm_val(alarm_q[g]),
            .skip     (mask_q[g]),
            .hit      (hits[g])
        );
    end

    cal_alarm_event u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .live_vec(live_vec),
        .hits    (hits),
        .mask    (mask_q),
        .cfg_wr  (cfg_wr),
        .clr     (clr),
        .snap_o  (snap),
        .flags_o (flags)
    );

    assign loc_status = flags;
    assign irq        = |flags;
endmodule

// File: rtl/cal_alarm_cmp_chk.sv
module cal_alarm_cmp_chk
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  clr_alarm_bit,
    input logic [FLAG_W-1:0]     loc_status,
    input logic [NUM_FIELDS-1:0] mask_q,
    input logic                  cfg_wr
);
    // R3: increment event appears two edges after a tick
    p_inc_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_status[FLAG_INC]) |-> $past(tick, 2));

    // R4: alarm event only follows a tick
    p_alarm_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_status[FLAG_ALM]) |-> $past(tick, 2));

    // R5: all-ones mask keeps the alarm off
    p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_status[FLAG_ALM]) |-> ($past(mask_q) != '1));

    // R7: configuration write in the evaluation cycle cancels the event
    p_cfg_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_status[FLAG_ALM]) |-> !$past(cfg_wr));

    // R8: clearing the alarm bit with no evaluation pending leaves it clear
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(LOC_OFS) && clr_alarm_bit && !$past(tick))
        |=> !loc_status[FLAG_ALM]);
endmodule

bind cal_alarm_cmp cal_alarm_cmp_chk #(
    .ADDR_W(ADDR_W)
) u_cal_alarm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .clr_alarm_bit(bus_wdata[cal_alarm_pkg::FLAG_ALM]),
    .loc_status   (loc_status),
    .mask_q       (mask_q),
    .cfg_wr       (cfg_wr)
);

// File: tb/cal_alarm_cmp_bench.sv
`timescale 1ns/1ps
module cal_alarm_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [5:0]  sec_i;
    logic [5:0]  min_i;
    logic [4:0]  hour_i;
    logic [4:0]  mday_i;
    logic [2:0]  wday_i;
    logic [8:0]  yday_i;
    logic [3:0]  month_i;
    logic [11:0] year_i;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [1:0]  loc_status;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 0;
    int          fw [8] = '{6, 6, 5, 5, 3, 9, 4, 12};
    int unsigned live_f [8];
    int unsigned alm_f [8];

    always #2.5 clk = ~clk;

    cal_alarm_cmp u_cal_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .mday_i(mday_i),
        .wday_i(wday_i), .yday_i(yday_i), .month_i(month_i), .year_i(year_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .loc_status(loc_status)
    );

    function automatic int unsigned keep(int i);
        return (32'd1 << fw[i]) - 32'd1;
    endfunction

    function automatic logic [1:0] exp_status(logic [7:0] m);
        bit hit = (m != 8'hFF);
        for (int i = 0; i < 8; i++) begin
            if (!m[i] && ((live_f[i] & keep(i)) != alm_f[i])) hit = 0;
        end
        return {hit, 1'b1};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_live();
        sec_i   = 6'(live_f[0]);
        min_i   = 6'(live_f[1]);
        hour_i  = 5'(live_f[2]);
        mday_i  = 5'(live_f[3]);
        wday_i  = 3'(live_f[4]);
        yday_i  = 9'(live_f[5]);
        month_i = 4'(live_f[6]);
        year_i  = 12'(live_f[7]);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick_once(bit scramble);
        @(negedge clk);
        drive_live();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (scramble) begin
            for (int i = 0; i < 8; i++) live_f[i] = (live_f[i] + 1) & keep(i);
            drive_live();
        end
        @(negedge clk);
    endtask

    task automatic load_alarms(logic [7:0] m);
        for (int i = 0; i < 8; i++) bus_write(8'(8'h60 + 4 * i), alm_f[i]);
        bus_write(8'h10, {24'd0, m});
        bus_write(8'h00, 32'h3);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  m;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd4242);
        rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < 8; i++) live_f[i] = 0;
        drive_live();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status", 32'(loc_status), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        bus_read(8'h10, rd); check("R1 mask", rd, 32'hFF);
        bus_read(8'h7C, rd); check("R1 alarm", rd, 32'd0);

        // R2 truncation, map, unmapped reads
        for (int i = 0; i < 8; i++) begin
            bus_write(8'(8'h60 + 4 * i), 32'hFFFF_FFFF);
            bus_read(8'(8'h60 + 4 * i), rd);
            check("R2 alarm width", rd, keep(i));
        end
        bus_write(8'h10, 32'h0000_01A5);
        bus_read(8'h10, rd); check("R2 mask bits", rd, 32'hA5);
        bus_read(8'h40, rd); check("R2 unmapped", rd, 32'd0);
        bus_read(8'h62, rd); check("R2 misaligned", rd, 32'd0);

        // R3 and R5: all fields match but mask is all ones
        for (int i = 0; i < 8; i++) begin alm_f[i] = keep(i); live_f[i] = keep(i); end
        load_alarms(8'hFF);
        tick_once(0);
        check("R5 alarm off", 32'(loc_status), 32'd1);
        check("R3 increment", 32'(loc_status[0]), 32'd1);
        check("R9 irq high", 32'(irq), 32'd1);
        bus_write(8'h00, 32'h1);
        check("R8 clear inc", 32'(loc_status), 32'd0);
        check("R9 irq low", 32'(irq), 32'd0);

        // R4 full match
        bus_write(8'h10, 32'h0);
        tick_once(0);
        check("R4 full match", 32'(loc_status), 32'd3);
        bus_write(8'h00, 32'h2);
        check("R8 partial clear", 32'(loc_status), 32'd1);
        bus_write(8'h00, 32'h1);

        // R4 masked field: year differs
        live_f[7] = live_f[7] ^ 32'h1;
        bus_write(8'h10, 32'h80);
        tick_once(0);
        check("R4 year masked", 32'(loc_status), 32'd3);
        bus_write(8'h00, 32'h3);
        bus_write(8'h10, 32'h00);
        tick_once(0);
        check("R4 year differs", 32'(loc_status), 32'd1);
        bus_write(8'h00, 32'h3);

        // R6 inputs change after the tick
        for (int i = 0; i < 8; i++) live_f[i] = alm_f[i];
        tick_once(1);
        check("R6 sampled at tick", 32'(loc_status), 32'd3);
        bus_write(8'h00, 32'h3);
        for (int i = 0; i < 8; i++) live_f[i] = alm_f[i];
        drive_live();
        repeat (5) @(negedge clk);
        check("R6 no tick no event", 32'(loc_status), 32'd0);

        // R7 write in the evaluation cycle
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        bus_wr = 1'b1; bus_addr = 8'h60; bus_wdata = alm_f[0];
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 suppressed", 32'(loc_status), 32'd1);
        bus_write(8'h00, 32'h3);
        tick_once(0);
        check("R7 next tick", 32'(loc_status), 32'd3);

        // R8 set and clear on the same edge
        bus_write(8'h10, 32'hFF);
        bus_write(8'h00, 32'h3);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h3;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 set wins", 32'(loc_status), 32'd1);

        // R4 R5 R9 constrained random
        for (int it = 0; it < 60; it++) begin
            logic [31:0] raw;
            m = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom & ($urandom | 8'h0F));
            for (int i = 0; i < 8; i++) begin
                raw = $urandom;
                alm_f[i] = raw & keep(i);
                live_f[i] = alm_f[i];
                if ($urandom % 6 == 0) live_f[i] = (live_f[i] + 1 + $urandom % 3) & keep(i);
            end
            for (int i = 0; i < 8; i++) bus_write(8'(8'h60 + 4 * i), alm_f[i] | 32'hFFFF_F000);
            bus_write(8'h10, {24'd0, m});
            bus_write(8'h00, 32'h3);
            tick_once(0);
            check("R4 random", 32'(loc_status), 32'(exp_status(m)));
            check("R9 random irq", 32'(irq), 32'd1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule